// File: doc/BRIEF.md
# Wired-to-Message Interrupt Converter

This block sits at the edge of an I/O subsystem. It watches a set of active-high, level-sensitive interrupt wires from local devices and reports them to a remote interrupt aggregator only as memory writes, never as wires. Each line belongs to one of three message groups: non-secure, system error or RAM error. Each line also carries a target index. Each group has its own doorbell address. A non-secure line behaves as a level: it gets a set write when it goes active and a clear write to a separate doorbell when it drops. The two error groups only ever announce an event: the write goes to the group's set doorbell and carries the target index.

Software programs the lines and the four doorbell addresses through a small write-only register port. Events are kept as per-line pending flags. A fixed-priority picker drains them one message at a time into a registered write-request master with a valid/ready handshake.

Top module: `w2m_irq_bridge`

## Requirements
- R1: After reset every line is disabled, all four doorbell addresses are zero, no message is pending and `m_valid` is low.
- R2: A rising edge on an enabled non-secure, system-error or RAM-error line produces exactly one write. Its address is that group's set doorbell, and its data is the line's target index, zero-extended into the low bits.
- R3: On a non-secure line in level mode (pulse bit 0), a falling edge while enabled produces one write to the non-secure clear doorbell, carrying the line's target index.
- R4: A falling edge produces no write on a system-error line, on a RAM-error line, or on a non-secure line in pulse mode (pulse bit 1).
- R5: A disabled line produces no write. Disabling a line discards any message it has pending that is not yet on the master port.
- R6: Enabling a line whose input is already high produces a set write, as if the line had just risen.
- R7: When several messages are pending, the lowest-numbered line is sent first. Within one line, a pending set goes before a pending clear.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr` and `m_data` hold their values. A held message is never dropped.
- R9: Group code 3 is reserved. A line configured with it behaves as disabled.
- R10: A rise on a line whose clear is still pending cancels that clear, so only a set is sent for the rise. A rise followed by a fall before either is sent yields a set and then a clear.
- R11: Configuration writes use `cfg_addr` below NUM_LINES to select a line. The data layout is: bit 0 enable; bits 2:1 group (0 non-secure, 1 system error, 2 RAM error, 3 reserved); bit 3 pulse mode; bits 8+IDX_W-1:8 target index. Addresses NUM_LINES to NUM_LINES+3 hold, in that order, the non-secure set doorbell, the non-secure clear doorbell, the system-error doorbell and the RAM-error doorbell, each taken from `cfg_wdata[ADDR_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Active-high level interrupt wires, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| m_valid | output | 1 | Message write request valid |
| m_ready | input | 1 | Downstream accepts the message this cycle |
| m_addr | output | ADDR_W | Doorbell address of the message |
| m_data | output | DATA_W | Message payload, target index in the low bits |

## Verification
The assertions check the following on every cycle: a stalled message stays stable, no pending flag survives on a disabled or reserved line, the picker grants at most one line and never skips a lower pending one, the payload never carries bits above the index width, and the port is idle right after reset. Only the bench's scenarios can show the rest. That covers the group-to-doorbell mapping, the absence of clear writes for error and pulse lines, enabling onto a high input, and the cancel-on-rise rule. It also covers the exact order in which a burst of simultaneous events leaves the port, which the bench shows by comparing a cycle-level behavioural model with a log of accepted writes.

// File: rtl/w2m_pkg.sv
// Package: shared encodings for the wired-to-message interrupt converter.
// Assumes the group codes and doorbell slot order are the ones software programs.
package w2m_pkg;
    typedef enum logic [1:0] {
        GRP_NSR = 2'd0,
        GRP_SEI = 2'd1,
        GRP_REI = 2'd2,
        GRP_RSV = 2'd3
    } grp_e;

    localparam int DB_NSR_SET = 0;
    localparam int DB_NSR_CLR = 1;
    localparam int DB_SEI     = 2;
    localparam int DB_REI     = 3;
    localparam int DB_COUNT   = 4;

    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_GRP_LO    = 1;
    localparam int CFG_PULSE_BIT = 3;
    localparam int CFG_IDX_LO    = 8;
endpackage

// File: rtl/w2m_cfg_regs.sv
// Module: per-line configuration and doorbell address registers.
// Holds the enable, group, pulse mode and target index of each line, plus four doorbell
// addresses. Assumes the write-only register port and the field layout in the package.
// It also exposes the next-cycle "live" value so the pending logic can drop state the same cycle.
module w2m_cfg_regs
    import w2m_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int CFG_AW    = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [31:0]                       cfg_wdata,
    output logic [NUM_LINES-1:0]              live_q,
    output logic [NUM_LINES-1:0]              live_d,
    output logic [NUM_LINES-1:0]              nsr_level_q,
    output logic [NUM_LINES-1:0][1:0]         grp_q,
    output logic [NUM_LINES-1:0][IDX_W-1:0]   idx_q,
    output logic [DB_COUNT-1:0][ADDR_W-1:0]   db_q
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic             hit;
        logic             en_r;
        logic             en_n;
        logic [1:0]       grp_r;
        logic [1:0]       grp_n;
        logic             pulse_r;
        logic [IDX_W-1:0] idx_r;

        assign hit   = cfg_we && (cfg_addr == CFG_AW'(g));
        assign en_n  = hit ? cfg_wdata[CFG_EN_BIT] : en_r;
        assign grp_n = hit ? cfg_wdata[CFG_GRP_LO +: 2] : grp_r;

        // Purpose: capture this line's configuration fields on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_r    <= 1'b0;
                grp_r   <= GRP_NSR;
                pulse_r <= 1'b0;
                idx_r   <= '0;
            end else begin
                en_r  <= en_n;
                grp_r <= grp_n;
                if (hit) begin
                    pulse_r <= cfg_wdata[CFG_PULSE_BIT];
                    idx_r   <= cfg_wdata[CFG_IDX_LO +: IDX_W];
                end
            end
        end

        assign live_q[g]      = en_r && (grp_r != GRP_RSV);
        assign live_d[g]      = en_n && (grp_n != GRP_RSV);
        assign nsr_level_q[g] = (grp_r == GRP_NSR) && !pulse_r;
        assign grp_q[g]       = grp_r;
        assign idx_q[g]       = idx_r;
    end

    for (genvar d = 0; d < DB_COUNT; d++) begin : g_db
        logic              hit;
        logic [ADDR_W-1:0] db_r;

        assign hit = cfg_we && (cfg_addr == CFG_AW'(NUM_LINES + d));

        // Purpose: hold one doorbell address.
        always_ff @(posedge clk) begin
            if (!rst_n)   db_r <= '0;
            else if (hit) db_r <= cfg_wdata[ADDR_W-1:0];
        end

        assign db_q[d] = db_r;
    end
endmodule

// File: rtl/w2m_edge_track.sv
// Module: per-line edge detection and pending set/clear flags.
// A set is queued when the line's active state (input high and line live) rises.
// A clear is queued when a live level-mode non-secure line falls. A rise cancels an
// unsent clear. Pending flags are masked by the next-cycle live state, so a line that
// is disabled or set to the reserved group keeps nothing queued.
// Assumes irq_in is already synchronous to clk.
module w2m_edge_track #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] live_q,
    input  logic [NUM_LINES-1:0] live_d,
    input  logic [NUM_LINES-1:0] nsr_level_q,
    input  logic [NUM_LINES-1:0] take_set,
    input  logic [NUM_LINES-1:0] take_clr,
    output logic [NUM_LINES-1:0] pend_set,
    output logic [NUM_LINES-1:0] pend_clr
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic act;
        logic act_r;
        logic in_r;
        logic set_evt;
        logic clr_evt;
        logic ps_r;
        logic pc_r;

        assign act     = irq_in[g] && live_q[g];
        assign set_evt = act && !act_r;
        assign clr_evt = live_q[g] && nsr_level_q[g] && in_r && !irq_in[g];

        // Purpose: remember last input and active state, update pending flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_r <= 1'b0;
                in_r  <= 1'b0;
                ps_r  <= 1'b0;
                pc_r  <= 1'b0;
            end else begin
                act_r <= act;
                in_r  <= irq_in[g];
                ps_r  <= ((ps_r && !take_set[g]) || set_evt) && live_d[g];
                pc_r  <= ((pc_r && !take_clr[g] && !set_evt) || clr_evt) && live_d[g];
            end
        end

        assign pend_set[g] = ps_r;
        assign pend_clr[g] = pc_r;
    end
endmodule

// File: rtl/w2m_pick.sv
// Module: fixed-priority message picker.
// Grants the lowest-numbered line with any pending message. Within that line a set
// wins over a clear. Pure combinational logic, no state.
module w2m_pick #(
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = 4
) (
    input  logic [NUM_LINES-1:0] pend_set,
    input  logic [NUM_LINES-1:0] pend_clr,
    output logic                 any,
    output logic [NUM_LINES-1:0] grant,
    output logic [LINE_W-1:0]    grant_idx,
    output logic                 is_clr
);
    logic [NUM_LINES-1:0] pend_any;
    assign pend_any = pend_set | pend_clr;

    // Purpose: scan from the top down so the lowest pending line wins.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        is_clr    = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend_any[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = LINE_W'(i);
                is_clr    = !pend_set[i];
            end
        end
    end

    assign any = |pend_any;
endmodule

// File: rtl/w2m_irq_bridge.sv
// Module: wired-to-message interrupt converter top.
// Turns level interrupt wires into doorbell writes on a valid/ready request master.
// The output is registered. A new message is loaded whenever the port is empty or the
// current one is being accepted, so one message can leave per cycle.
// Assumes irq_in is synchronous to clk and that the downstream fabric keeps its own ordering.
module w2m_irq_bridge
    import w2m_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CFG_AW    = $clog2(NUM_LINES + DB_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [DATA_W-1:0]    m_data
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0]            live_q;
    logic [NUM_LINES-1:0]            live_d;
    logic [NUM_LINES-1:0]            nsr_level_q;
    logic [NUM_LINES-1:0][1:0]       grp_q;
    logic [NUM_LINES-1:0][IDX_W-1:0] idx_q;
    logic [DB_COUNT-1:0][ADDR_W-1:0] db_q;
    logic [NUM_LINES-1:0]            pend_set;
    logic [NUM_LINES-1:0]            pend_clr;
    logic [NUM_LINES-1:0]            take_set;
    logic [NUM_LINES-1:0]            take_clr;
    logic [NUM_LINES-1:0]            grant;
    logic [LINE_W-1:0]               grant_idx;
    logic                            any;
    logic                            is_clr;
    logic                            load;
    logic [ADDR_W-1:0]               next_addr;

    w2m_cfg_regs #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .live_q(live_q), .live_d(live_d),
        .nsr_level_q(nsr_level_q), .grp_q(grp_q), .idx_q(idx_q), .db_q(db_q)
    );

    w2m_edge_track #(.NUM_LINES(NUM_LINES)) u_track (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .live_q(live_q),
        .live_d(live_d), .nsr_level_q(nsr_level_q), .take_set(take_set),
        .take_clr(take_clr), .pend_set(pend_set), .pend_clr(pend_clr)
    );

    w2m_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_pick (
        .pend_set(pend_set), .pend_clr(pend_clr), .any(any), .grant(grant),
        .grant_idx(grant_idx), .is_clr(is_clr)
    );

    assign load     = !m_valid || m_ready;
    assign take_set = (load && any && !is_clr) ? grant : '0;
    assign take_clr = (load && any &&  is_clr) ? grant : '0;

    // Purpose: map the granted line's group and message kind to a doorbell address.
    always_comb begin
        if (is_clr) begin
            next_addr = db_q[DB_NSR_CLR];
        end else begin
            unique case (grp_e'(grp_q[grant_idx]))
                GRP_SEI: next_addr = db_q[DB_SEI];
                GRP_REI: next_addr = db_q[DB_REI];
                default: next_addr = db_q[DB_NSR_SET];
            endcase
        end
    end

    // Purpose: output register of the write-request master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_addr  <= '0;
            m_data  <= '0;
        end else if (load) begin
            m_valid <= any;
            if (any) begin
                m_addr <= next_addr;
                m_data <= DATA_W'(idx_q[grant_idx]);
            end
        end
    end
endmodule

// File: rtl/w2m_irq_bridge_chk.sv
// Module: assertion checker bound to the converter top.
// Watches the master port, the pending flags and the picker grant.
module w2m_irq_bridge_chk #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 m_valid,
    input logic                 m_ready,
    input logic [ADDR_W-1:0]    m_addr,
    input logic [DATA_W-1:0]    m_data,
    input logic [NUM_LINES-1:0] pend_set,
    input logic [NUM_LINES-1:0] pend_clr,
    input logic [NUM_LINES-1:0] live_q,
    input logic [NUM_LINES-1:0] grant
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !m_valid); // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data))); // R8

    AST_NO_PEND_ON_DEAD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_set | pend_clr) & ~live_q) == '0)); // R5

    AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (((grant - NUM_LINES'(1)) & (pend_set | pend_clr) & {NUM_LINES{|grant}}) == '0)); // R7

    AST_PAYLOAD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ((m_data >> IDX_W) == '0)); // R2
endmodule

bind w2m_irq_bridge w2m_irq_bridge_chk #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_addr(m_addr), .m_data(m_data), .pend_set(pend_set), .pend_clr(pend_clr),
    .live_q(live_q), .grant(grant)
);

// File: tb/tb_w2m_irq_bridge.sv
`timescale 1ns/1ps
module tb_w2m_irq_bridge;
    localparam int N      = 16;
    localparam int IDX_W  = 8;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int CAW    = 5;
    localparam logic [31:0] DB_SET = 32'h4000_0040;
    localparam logic [31:0] DB_CLR = 32'h4000_0048;
    localparam logic [31:0] DB_SE  = 32'h4000_0050;
    localparam logic [31:0] DB_RE  = 32'h4000_0058;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq = '0;
    logic           cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic           m_valid;
    logic           m_ready = 1'b1;
    logic [AW-1:0]  m_addr;
    logic [DW-1:0]  m_data;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    w2m_irq_bridge #(.NUM_LINES(N), .IDX_W(IDX_W), .ADDR_W(AW), .DATA_W(DW), .CFG_AW(CAW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .m_valid(m_valid), .m_ready(m_ready),
        .m_addr(m_addr), .m_data(m_data)
    );

    // Behavioural reference model state
    bit          en_m[N];
    int          grp_m[N];
    bit          pls_m[N];
    int          idx_m[N];
    logic [31:0] db_m[4];
    bit          actq_m[N];
    bit          inq_m[N];
    bit          ps_m[N];
    bit          pc_m[N];
    bit          mv;
    logic [31:0] ma;
    logic [31:0] md;

    always @(posedge clk) begin
        bit se[N];
        bit ce[N];
        int w;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                en_m[i] = 0; grp_m[i] = 0; pls_m[i] = 0; idx_m[i] = 0;
                actq_m[i] = 0; inq_m[i] = 0; ps_m[i] = 0; pc_m[i] = 0;
            end
            for (int d = 0; d < 4; d++) db_m[d] = '0;
            mv = 0; ma = '0; md = '0;
        end else begin
            if (!mv || m_ready) begin
                w = -1;
                for (int i = 0; i < N; i++) if (w < 0 && (ps_m[i] || pc_m[i])) w = i;
                if (w >= 0) begin
                    mv = 1;
                    md = idx_m[w];
                    if (ps_m[w]) begin
                        ps_m[w] = 0;
                        ma = (grp_m[w] == 1) ? db_m[2] : (grp_m[w] == 2) ? db_m[3] : db_m[0];
                    end else begin
                        pc_m[w] = 0;
                        ma = db_m[1];
                    end
                end else begin
                    mv = 0;
                end
            end
            for (int i = 0; i < N; i++) begin
                bit live;
                bit act;
                live = en_m[i] && grp_m[i] != 3;
                act  = irq[i] && live;
                se[i] = act && !actq_m[i];
                ce[i] = live && grp_m[i] == 0 && !pls_m[i] && inq_m[i] && !irq[i];
                actq_m[i] = act;
                inq_m[i]  = irq[i];
            end
            if (cfg_we) begin
                if (cfg_addr < N) begin
                    en_m[cfg_addr]  = cfg_wdata[0];
                    grp_m[cfg_addr] = cfg_wdata[2:1];
                    pls_m[cfg_addr] = cfg_wdata[3];
                    idx_m[cfg_addr] = cfg_wdata[15:8];
                end else if (cfg_addr < N + 4) begin
                    db_m[cfg_addr - N] = cfg_wdata;
                end
            end
            for (int i = 0; i < N; i++) begin
                bit live;
                live = en_m[i] && grp_m[i] != 3;
                pc_m[i] = ((pc_m[i] && !se[i]) || ce[i]) && live;
                ps_m[i] = (ps_m[i] || se[i]) && live;
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, and a log of accepted writes
    logic [63:0] log_q[$];
    logic [63:0] exp_q[$];

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "m_valid vs model", {63'd0, m_valid}, {63'd0, mv});
            if (mv) begin
                chk(cur_req, "m_addr vs model", {32'd0, m_addr}, {32'd0, ma});
                chk(cur_req, "m_data vs model", {32'd0, m_data}, {32'd0, md});
            end
            if (m_valid && m_ready) log_q.push_back({m_addr, m_data});
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(int a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = CAW'(a); cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] mk(bit en, int grp, bit pls, int idx);
        return (32'(idx) << 8) | (32'(pls) << 3) | (32'(grp) << 1) | 32'(en);
    endfunction

    task automatic expect_w(logic [31:0] a, logic [31:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic check_log(string req);
        chk(req, "write count", 64'(log_q.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            chk(req, $sformatf("write %0d addr/data", i), log_q[i], exp_q[i]);
        log_q.delete();
        exp_q.delete();
    endtask

    task automatic run_all();
        // R1: reset state
        step(3);
        chk("R1", "m_valid in reset", {63'd0, m_valid}, 64'd0);
        rst_n = 1'b1;
        step(2);
        chk("R1", "m_valid after reset", {63'd0, m_valid}, 64'd0);
        chk("R1", "m_addr after reset", {32'd0, m_addr}, 64'd0);
        irq[0] = 1'b1; step(4); irq[0] = 1'b0; step(2);
        check_log("R1");

        // R11: doorbell programming
        cur_req = "R11";
        cfg_write(N + 0, DB_SET);
        cfg_write(N + 1, DB_CLR);
        cfg_write(N + 2, DB_SE);
        cfg_write(N + 3, DB_RE);

        // R2 R3: non-secure level line
        cur_req = "R2";
        cfg_write(3, mk(1, 0, 0, 8'h45));
        irq[3] = 1'b1; step(5);
        cur_req = "R3";
        irq[3] = 1'b0; step(5);
        expect_w(DB_SET, 32'h45); expect_w(DB_CLR, 32'h45);
        check_log("R3");

        // R4: error groups and pulse mode give no clear
        cur_req = "R4";
        cfg_write(5, mk(1, 1, 0, 8'h12));
        cfg_write(6, mk(1, 2, 0, 8'h07));
        cfg_write(7, mk(1, 0, 1, 8'h77));
        irq[5] = 1'b1; step(5); irq[5] = 1'b0; step(5);
        irq[6] = 1'b1; step(5); irq[6] = 1'b0; step(5);
        irq[7] = 1'b1; step(5); irq[7] = 1'b0; step(5);
        expect_w(DB_SE, 32'h12); expect_w(DB_RE, 32'h07); expect_w(DB_SET, 32'h77);
        check_log("R4");

        // R5: disabled line silent; disabling drops a queued message
        cur_req = "R5";
        irq[8] = 1'b1; step(4); irq[8] = 1'b0; step(4);
        check_log("R5");
        cfg_write(2, mk(1, 0, 0, 8'h22));
        cfg_write(9, mk(1, 0, 0, 8'h09));
        m_ready = 1'b0;
        irq[2] = 1'b1; step(3);
        irq[9] = 1'b1; step(2);
        cfg_write(9, mk(0, 0, 0, 8'h09));
        m_ready = 1'b1; step(3);
        irq[2] = 1'b0; irq[9] = 1'b0; step(5);
        expect_w(DB_SET, 32'h22); expect_w(DB_CLR, 32'h22);
        check_log("R5");

        // R6: enabling onto a high input
        cur_req = "R6";
        irq[10] = 1'b1; step(3);
        check_log("R6");
        cfg_write(10, mk(1, 0, 0, 8'h0A)); step(4);
        irq[10] = 1'b0; step(5);
        expect_w(DB_SET, 32'h0A); expect_w(DB_CLR, 32'h0A);
        check_log("R6");

        // R7 R8: simultaneous events under a stall
        cur_req = "R8";
        cfg_write(11, mk(1, 0, 0, 8'h3B));
        cfg_write(12, mk(1, 0, 0, 8'h3C));
        cfg_write(13, mk(1, 0, 0, 8'h3D));
        m_ready = 1'b0;
        irq[13] = 1'b1; irq[12] = 1'b1; irq[11] = 1'b1; step(4);
        chk("R8", "stalled valid", {63'd0, m_valid}, 64'd1);
        chk("R8", "stalled data", {32'd0, m_data}, 64'h3B);
        step(3);
        chk("R8", "still stalled addr", {32'd0, m_addr}, {32'd0, DB_SET});
        chk("R8", "still stalled data", {32'd0, m_data}, 64'h3B);
        cur_req = "R7";
        m_ready = 1'b1; step(6);
        irq[13] = 1'b0; irq[12] = 1'b0; irq[11] = 1'b0; step(6);
        expect_w(DB_SET, 32'h3B); expect_w(DB_SET, 32'h3C); expect_w(DB_SET, 32'h3D);
        expect_w(DB_CLR, 32'h3B); expect_w(DB_CLR, 32'h3C); expect_w(DB_CLR, 32'h3D);
        check_log("R7");

        // R9: reserved group behaves as disabled
        cur_req = "R9";
        cfg_write(14, mk(1, 3, 0, 8'h0E));
        irq[14] = 1'b1; step(4); irq[14] = 1'b0; step(4);
        check_log("R9");

        // R10: set then clear ordering, and cancel-on-rise
        cur_req = "R10";
        cfg_write(1, mk(1, 0, 0, 8'h01));
        cfg_write(15, mk(1, 0, 0, 8'h2F));
        m_ready = 1'b0;
        irq[1] = 1'b1; step(3);
        irq[15] = 1'b1; step(1); irq[15] = 1'b0; step(1);
        m_ready = 1'b1; step(6);
        expect_w(DB_SET, 32'h01); expect_w(DB_SET, 32'h2F); expect_w(DB_CLR, 32'h2F);
        check_log("R10");
        m_ready = 1'b0;
        irq[1] = 1'b0; step(3);
        irq[15] = 1'b1; step(1); irq[15] = 1'b0; step(1); irq[15] = 1'b1; step(1);
        m_ready = 1'b1; step(6);
        irq[15] = 1'b0; step(5);
        expect_w(DB_CLR, 32'h01); expect_w(DB_SET, 32'h2F); expect_w(DB_CLR, 32'h2F);
        check_log("R10");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL R1 watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule